// File: doc/BRIEF.md
# Strobed RAM Access Sequencer

This block is a clocked controller placed between a simple host request port and a static RAM that latches its address on the falling edge of an enable strobe. It owns four active-low strobes: enable, two chip selects and write. It also owns a direction flag that says when the controller drives the shared data bus. The host pulses a request with an address, a write flag and write data. The sequencer plays out a fixed sequence of phases and pulses a one-clock completion flag when the access is over. Read data comes back with that flag.

The sequence is built so that the RAM's output drivers and the controller's data drivers are never on at the same time. On a write, the write strobe goes low while both selects are still high, so the RAM never enters read mode and data can go on the bus at once. The write ends when the selects and the write strobe rise together. The controller keeps driving data for a hold phase after that edge. Then the enable returns high before a new access may begin. Every phase length is a parameter counted in clock cycles, with a minimum of one.

Top module: `strobe_ram_seq`

## Requirements
- R1: After reset, all four strobes are high (1), the bus drive flag is low, and busy and done are low.
- R2: A request seen while idle is accepted: the latched address appears on the RAM address output on the next cycle and stays unchanged for the whole access. The enable strobe is low for every cycle from that cycle until recovery.
- R3: On a write, the write strobe is low with both selects high for exactly P_WSETUP cycles before the selects fall. The bus drive flag is high from the first of those cycles.
- R4: A write ends when the selects and the write strobe rise on the same edge. The bus drive flag stays high for exactly P_HOLD further cycles, then falls together with the enable strobe's rise.
- R5: The bus drive flag is never high in a cycle where enable and both selects are low and the write strobe is high (RAM outputs on).
- R6: On a read, enable and both selects are low with the write strobe high for P_READ cycles. The bus value in the last of these cycles is returned on the read data output with done.
- R7: Done is high for exactly one cycle, in the last recovery cycle. Counted from the accepting edge, that cycle comes P_LATCH+P_WSETUP+P_WACTIVE+P_HOLD+P_RECOVER cycles later for a write and P_LATCH+P_READ+P_RECOVER for a read.
- R8: Busy is high from acceptance through the done cycle. A request made while busy is ignored and changes neither the access in progress nor any RAM location.
- R9: A written value is stored at the latched address, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_i | input | 1 | access request pulse |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | access address |
| wdata_i | input | DW | write data |
| busy_o | output | 1 | access in progress |
| done_o | output | 1 | one-cycle completion pulse |
| rdata_o | output | DW | data returned by a read |
| ram_addr_o | output | AW | address to the RAM |
| ram_e_n_o | output | 1 | address latch / enable strobe, active low |
| ram_s1_n_o | output | 1 | select 1, active low |
| ram_s2_n_o | output | 1 | select 2, active low |
| ram_w_n_o | output | 1 | write strobe, active low |
| bus_drive_o | output | 1 | controller drives the data bus |
| bus_wdata_o | output | DW | data for the bus when driving |
| bus_rdata_i | input | DW | data bus value seen from the RAM |

## Verification
Two things can fall in the same cycle. The first is a host request and a busy sequencer. The bench provokes it by pulsing a second write request with a different address in the middle of a write. It then judges the result from the unchanged latency of the running access and a later read of the intruding address, which must still hold its old value. The second is the RAM enabling its outputs while the controller is still driving. A bench RAM model watches every cycle for that overlap. It also counts the cycles with the write strobe low before the selects fall, and the drive cycles after the terminating edge, and compares both with the phase parameters over a sweep of every address.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_WSETUP,
    ST_WACTIVE,
    ST_HOLD,
    ST_READ,
    ST_RECOVER
  } seq_state_e;

  typedef struct packed {
    logic e_n;
    logic s_n;
    logic w_n;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import seq_pkg::*;
#(
  parameter int CW        = 4,
  parameter int P_LATCH   = 1,
  parameter int P_WSETUP  = 1,
  parameter int P_WACTIVE = 2,
  parameter int P_HOLD    = 1,
  parameter int P_READ    = 2,
  parameter int P_RECOVER = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          is_wr_i,
  input  logic          last_i,
  output seq_state_e    state_o,
  output logic          accept_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          done_o
);
  seq_state_e state_q, state_d;

  function automatic logic [CW-1:0] phase_cnt(seq_state_e st);
    int len;
    case (st)
      ST_LATCH:   len = P_LATCH;
      ST_WSETUP:  len = P_WSETUP;
      ST_WACTIVE: len = P_WACTIVE;
      ST_HOLD:    len = P_HOLD;
      ST_READ:    len = P_READ;
      ST_RECOVER: len = P_RECOVER;
      default:    len = 1;
    endcase
    return CW'(len - 1);
  endfunction

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d  = ST_LATCH;
        accept_o = 1'b1;
      end
      ST_LATCH:   if (last_i) state_d = is_wr_i ? ST_WSETUP : ST_READ;
      ST_WSETUP:  if (last_i) state_d = ST_WACTIVE;
      ST_WACTIVE: if (last_i) state_d = ST_HOLD;
      ST_HOLD:    if (last_i) state_d = ST_RECOVER;
      ST_READ:    if (last_i) state_d = ST_RECOVER;
      ST_RECOVER: if (last_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  assign load_o     = (state_d != state_q);
  assign load_val_o = phase_cnt(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/seq_strobe_dec.sv
module seq_strobe_dec
  import seq_pkg::*;
(
  input  seq_state_e state_i,
  output strobe_t    strb_o
);
  always_comb begin
    strb_o = '{e_n: 1'b1, s_n: 1'b1, w_n: 1'b1, drive: 1'b0};
    unique case (state_i)
      ST_LATCH:   strb_o = '{e_n: 1'b0, s_n: 1'b1, w_n: 1'b1, drive: 1'b0};
      ST_WSETUP:  strb_o = '{e_n: 1'b0, s_n: 1'b1, w_n: 1'b0, drive: 1'b1};
      ST_WACTIVE: strb_o = '{e_n: 1'b0, s_n: 1'b0, w_n: 1'b0, drive: 1'b1};
      ST_HOLD:    strb_o = '{e_n: 1'b0, s_n: 1'b1, w_n: 1'b1, drive: 1'b1};
      ST_READ:    strb_o = '{e_n: 1'b0, s_n: 1'b0, w_n: 1'b1, drive: 1'b0};
      default:    strb_o = '{e_n: 1'b1, s_n: 1'b1, w_n: 1'b1, drive: 1'b0};
    endcase
  end
endmodule

// File: rtl/strobe_ram_seq.sv
module strobe_ram_seq
  import seq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 4,
  parameter int P_LATCH   = 1,
  parameter int P_WSETUP  = 1,
  parameter int P_WACTIVE = 2,
  parameter int P_HOLD    = 1,
  parameter int P_READ    = 2,
  parameter int P_RECOVER = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_e_n_o,
  output logic          ram_s1_n_o,
  output logic          ram_s2_n_o,
  output logic          ram_w_n_o,
  output logic          bus_drive_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i
);
  function automatic int max_len();
    int m = P_LATCH;
    if (P_WSETUP  > m) m = P_WSETUP;
    if (P_WACTIVE > m) m = P_WACTIVE;
    if (P_HOLD    > m) m = P_HOLD;
    if (P_READ    > m) m = P_READ;
    if (P_RECOVER > m) m = P_RECOVER;
    return m;
  endfunction

  localparam int MAXLEN = max_len();
  localparam int CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  seq_state_e    state;
  strobe_t       strb;
  logic          accept, load, last, cap_en;
  logic [CW-1:0] load_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q;

  seq_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .last_o(last)
  );

  seq_ctrl_fsm #(
    .CW(CW), .P_LATCH(P_LATCH), .P_WSETUP(P_WSETUP), .P_WACTIVE(P_WACTIVE),
    .P_HOLD(P_HOLD), .P_READ(P_READ), .P_RECOVER(P_RECOVER)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .is_wr_i(wr_q), .last_i(last),
    .state_o(state), .accept_o(accept), .load_o(load), .load_val_o(load_val),
    .done_o(done_o)
  );

  seq_strobe_dec u_dec (.state_i(state), .strb_o(strb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wr_q    <= wr_i;
    end
  end

  assign cap_en = (state == ST_READ) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_rdata_i;
  end

  assign busy_o      = (state != ST_IDLE);
  assign rdata_o     = rdata_q;
  assign ram_addr_o  = addr_q;
  assign ram_e_n_o   = strb.e_n;
  assign ram_s1_n_o  = strb.s_n;
  assign ram_s2_n_o  = strb.s_n;
  assign ram_w_n_o   = strb.w_n;
  assign bus_drive_o = strb.drive;
  assign bus_wdata_o = wdata_q;

  // R5: controller drive and RAM output enable never overlap
  assert_no_conflict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_drive_o && !ram_e_n_o && !ram_s1_n_o && !ram_s2_n_o && ram_w_n_o));

  // R3: selects may fall during a write only after W was already low
  assert_w_before_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_s1_n_o) && !ram_w_n_o) |-> $past(!ram_w_n_o));

  // R4: drive continues past the terminating edge
  assert_hold_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_w_n_o) |-> bus_drive_o);

  // R7: done lasts one cycle and the block is idle afterwards
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R8: address held steady for the whole access
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ram_addr_o));

  // R2: selects only while the enable strobe is low
  assert_sel_inside_e_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_s1_n_o |-> !ram_e_n_o);
endmodule

// File: tb/strobe_ram_seq_bench.sv
module strobe_ram_seq_bench;
  localparam int AW = 8, DW = 4;
  localparam int TL = 1, TWS = 1, TWA = 2, TH = 1, TRD = 2, TRC = 2;
  localparam int WR_LAT = TL + TWS + TWA + TH + TRC;
  localparam int RD_LAT = TL + TRD + TRC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, e_n, s1_n, s2_n, w_n, drive;
  logic [DW-1:0] rdata, bus_wd, bus_rd;
  logic [AW-1:0] ram_addr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  strobe_ram_seq #(
    .AW(AW), .DW(DW), .P_LATCH(TL), .P_WSETUP(TWS), .P_WACTIVE(TWA),
    .P_HOLD(TH), .P_READ(TRD), .P_RECOVER(TRC)
  ) u_strobe_ram_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ram_addr_o(ram_addr), .ram_e_n_o(e_n), .ram_s1_n_o(s1_n),
    .ram_s2_n_o(s2_n), .ram_w_n_o(w_n), .bus_drive_o(drive),
    .bus_wdata_o(bus_wd), .bus_rdata_i(bus_rd)
  );

  // RAM model with per-cycle protocol monitor
  logic [DW-1:0] mem [256];
  logic [AW-1:0] lat = '0;
  logic pe = 1'b1, pact = 1'b0, psel = 1'b1;
  int pre_w = 0, post_drv = 0, conflicts = 0, sel_wo_w = 0;
  logic ram_oe;
  assign ram_oe = !e_n && !s1_n && !s2_n && w_n;
  assign bus_rd = ram_oe ? mem[lat] : '0;

  always @(negedge clk) begin
    logic act;
    act = !e_n && !s1_n && !s2_n && !w_n;
    if (pe && !e_n) lat = ram_addr;
    if (pact && !act) mem[lat] = bus_wd;
    if (drive && ram_oe) conflicts++;
    if (!w_n && s1_n && !e_n) pre_w++;
    if (drive && w_n) post_drv++;
    if (psel && !s1_n && w_n && drive) sel_wo_w++;
    pact = act; pe = e_n; psel = s1_n;
  end

  task automatic chk(input bit ok, input string rq, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act_v, exp_v);
    end
  endtask

  task automatic do_op(input bit w, input int a, input int d, input bit inject,
                       input int ia, output int got);
    int n;
    bit busy_ok;
    pre_w = 0; post_drv = 0; conflicts = 0; sel_wo_w = 0;
    busy_ok = 1'b1;
    req = 1'b1; wr = w; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    req = 1'b0;
    n = 1;
    chk(ram_addr == AW'(a) && !e_n, "R2", int'(ram_addr), a);
    while (!done && n < 60) begin
      if (!busy) busy_ok = 1'b0;
      if (inject && n == 2) begin
        req = 1'b1; wr = 1'b1; addr = AW'(ia); wdata = DW'(d ^ 4'hF);
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
      n++;
      if (n > 2 && busy && ram_addr != AW'(a)) busy_ok = 1'b0;
    end
    req = 1'b0;
    got = int'(rdata);
    chk(n == (w ? WR_LAT : RD_LAT), "R7", n, w ? WR_LAT : RD_LAT);
    chk(busy_ok && busy, "R8", int'(busy_ok), 1);
    chk(conflicts == 0, "R5", conflicts, 0);
    if (w) begin
      chk(pre_w == TWS && sel_wo_w == 0, "R3", pre_w, TWS);
      chk(post_drv == TH, "R4", post_drv, TH);
    end
    @(negedge clk);
    chk(!done && !busy, "R7", int'(done), 0);
  endtask

  initial begin
    int got;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(e_n && s1_n && s2_n && w_n && !drive && !busy && !done, "R1",
        int'({e_n, s1_n, s2_n, w_n, drive, busy, done}), 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(e_n && !busy, "R1", int'(e_n), 1);
    for (int a = 0; a < 256; a++) do_op(1'b1, a, (a * 7 + 3) & 15, 1'b0, 0, got);
    for (int a = 0; a < 256; a++) begin
      do_op(1'b0, a, 0, 1'b0, 0, got);
      chk(got == ((a * 7 + 3) & 15), "R6 R9", got, (a * 7 + 3) & 15);
    end
    // request while busy: address 9 must keep its value
    do_op(1'b1, 5, 4'hA, 1'b1, 9, got);
    do_op(1'b0, 9, 0, 1'b0, 0, got);
    chk(got == ((9 * 7 + 3) & 15), "R8", got, (9 * 7 + 3) & 15);
    do_op(1'b0, 5, 0, 1'b0, 0, got);
    chk(got == 4'hA, "R9", got, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule